// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two 32-bit two's-complement operands over several clock cycles and returns the full 64-bit signed product. The product comes out as an upper word and a lower word. A one-cycle request captures both operands. The block then runs one radix-2 Booth step per clock. Each step looks at the current low bit of the multiplier and the bit that was shifted out just before it. From that pair it adds the multiplicand into the upper half of a combined working register, subtracts it, or leaves the upper half unchanged. The whole register then shifts right by one place with sign extension.

The working register has three parts: a 33-bit accumulator, a 32-bit multiplier section and a single history bit. The accumulator is one bit wider than an operand, so a sum or difference cannot overflow before the shift. A busy flag covers the whole computation. A one-cycle done pulse marks the moment the product is ready. The product stays on the outputs until the next accepted request.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy_o`=0, `done_o`=0, `hi_o`=0 and `lo_o`=0.
- R2: When idle, a clock edge with `start_i`=1 captures both operands and sets `busy_o` after that edge.
- R3: `done_o` rises after the 32nd clock edge that follows the capture edge. At that same edge `busy_o` falls. `done_o` is high for exactly one cycle.
- R4: After done, {`hi_o`,`lo_o`} equals the signed 64-bit product of `mcand_i` and `mplier_i` as captured. This holds for the extreme values: most negative times most negative, most negative times -1, zero operands, and alternating bit patterns.
- R5: `hi_o` holds product bits 63..32 and `lo_o` holds bits 31..0. Both stay unchanged while idle with no request, whatever the operand inputs do.
- R6: A `start_i` pulse while busy is ignored. The running computation completes on its original schedule with its original result.
- R7: Changes to `mcand_i` or `mplier_i` after the capture edge do not affect the result.
- R8: The step pair of (current multiplier bit, previous bit) is decoded as 00 or 11 = no operation, 01 = add the multiplicand, 10 = subtract it. The previous bit is 0 at the first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request; accepted only when idle |
| mcand_i | input | 32 | Signed multiplicand |
| mplier_i | input | 32 | Signed multiplier |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse, product ready |
| hi_o | output | 32 | Product bits 63..32 |
| lo_o | output | 32 | Product bits 31..0 |

## Verification
The hardest situation to reach from the ports is a long run of carries or borrows through the 33rd accumulator bit. Only a most-negative multiplicand combined with long runs of ones in the multiplier drives the accumulator to its extremes. Directed operands such as most negative times most negative, most negative times -1 and alternating patterns go there explicitly. Fixed-seed random pairs, some with their upper bits forced to all ones or all zeros, cover the rest. A request injected in the middle of a run, together with changed operand inputs, shows that the running product and its schedule are untouched.

// File: rtl/booth_pkg.sv
// Shared definitions for the sequential Booth multiplier.
// Assumes operands are two's-complement and of equal width.
package booth_pkg;
    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// Decodes a (current, previous) multiplier bit pair into a Booth action.
// Assumes prev_bit is the bit shifted out in the step before (0 at the start).
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    // Pair decode: 10 subtracts, 01 adds, equal bits do nothing.
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   op = BOP_SUB;
            2'b01:   op = BOP_ADD;
            default: op = BOP_NONE;
        endcase
    end

    // R8: the decoder never asks for an action when the bits agree
    always_comb begin
        if (cur_bit == prev_bit)
            p_equal_bits_noop_r8: assert (op == BOP_NONE);
    end
endmodule

// File: rtl/booth_addsub.sv
// Adds, subtracts or passes the multiplicand against a one-bit-wider accumulator.
// Assumes the multiplicand is signed; it is sign-extended to the accumulator width.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH-1:0] mcand,
    input  booth_op_e        op,
    output logic [WIDTH:0]   result
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0] mc_ext;

    // Sign-extend the multiplicand to the accumulator width.
    assign mc_ext = {mcand[WIDTH-1], mcand};

    // Select the arithmetic action chosen by the recoder.
    always_comb begin
        unique case (op)
            BOP_ADD: result = acc + mc_ext;
            BOP_SUB: result = acc + ~mc_ext + AW'(1);
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
// Sequences one load cycle and STEPS Booth step cycles, then pulses done.
// Assumes start is ignored while busy; reset is synchronous, active low.
module booth_ctrl #(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign load = start && !busy;
    assign step = busy;

    // Step counter, busy flag and one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end else if (busy) begin
                if (cnt_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R2: an idle request makes the block busy
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R3: done lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: done only follows a busy cycle
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    // R6: a request during a run does not restart the count
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/booth_mul_seq.sv
// Sequential signed multiplier using radix-2 Booth steps, one per clock.
// Assumes two's-complement operands; the product is valid from done and is
// held until the next accepted request.
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic             load, step;
    logic [WIDTH:0]   acc_q;
    logic [WIDTH-1:0] mlo_q;
    logic             prev_q;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH:0]   sum;
    booth_op_e        op;

    booth_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .load  (load),
        .step  (step),
        .busy  (busy_o),
        .done  (done_o)
    );

    booth_recode u_recode (
        .cur_bit  (mlo_q[0]),
        .prev_bit (prev_q),
        .op       (op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc    (acc_q),
        .mcand  (mcand_q),
        .op     (op),
        .result (sum)
    );

    // Working register: load operands, or apply one step and shift right arithmetically.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mlo_q   <= '0;
            prev_q  <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            mlo_q   <= mplier_i;
            prev_q  <= 1'b0;
            mcand_q <= mcand_i;
        end else if (step) begin
            acc_q   <= {sum[WIDTH], sum[WIDTH:1]};
            mlo_q   <= {sum[0], mlo_q[WIDTH-1:1]};
            prev_q  <= mlo_q[0];
        end
    end

    assign hi_o = acc_q[WIDTH-1:0];
    assign lo_o = mlo_q;

    // R5: the product is held while idle without a request
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));
    // R7: the latched multiplicand never changes during a run
    p_mcand_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mcand_q));
    // R2: a load clears the accumulator and the history bit
    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == '0 && !prev_q && lo_o == $past(mplier_i)));
endmodule

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    booth_mul_seq #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return 64'(sa * sb);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one product; optionally injects a request and operand changes mid-run.
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
        int k;
        logic [63:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", 64'(busy_o), 64'd1);
        k = 0;
        while (k < 40) begin
            if (inject && k == 10) begin
                start_i = 1'b1; mcand_i = ~a; mplier_i = b ^ 32'h5A5A_1234;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            k++;
            if (done_o) break;
        end
        check(inject ? "R6 cycles to done" : "R3 cycles to done", 64'(k), 64'd32);
        check("R3 busy low at done", 64'(busy_o), 64'd0);
        check(inject ? "R7 product" : "R4 product", {hi_o, lo_o}, exp);
        @(negedge clk);
        check("R3 done one cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        logic [W-1:0] a, b, ha, hl;
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset busy", 64'(busy_o), 64'd0);
        check("R1 reset done", 64'(done_o), 64'd0);
        check("R1 reset product", {hi_o, lo_o}, 64'd0);
        rst_n = 1'b1;

        // R4 and R8 corners: all pair codes, extremes, alternation
        run_mul(32'h8000_0000, 32'h8000_0000, 1'b0);
        run_mul(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_mul(32'hFFFF_FFFF, 32'h8000_0000, 1'b0);
        run_mul(32'h0000_0000, 32'h1234_5678, 1'b0);
        run_mul(32'h8765_4321, 32'h0000_0000, 1'b0);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        run_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
        run_mul(32'h8000_0000, 32'h5555_5555, 1'b0);
        run_mul(32'h8000_0000, 32'hAAAA_AAAA, 1'b0);
        run_mul(32'h0000_0003, 32'hFFFF_FFFD, 1'b0);

        // R5: hold with no request while operands wander; hi/lo halves
        ha = hi_o; hl = lo_o;
        check("R5 hi is upper word", 64'(hi_o), 64'(ref_mul(32'h3, 32'hFFFF_FFFD) >> 32));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            mcand_i = $urandom; mplier_i = $urandom;
        end
        check("R5 held while idle", {hi_o, lo_o}, {ha, hl});

        // R6 and R7: mid-run request and operand change
        run_mul(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1);
        run_mul(32'h8000_0000, 32'h8000_0000, 1'b1);

        // R4 random, with biased upper bits
        for (int i = 0; i < 150; i++) begin
            a = $urandom; b = $urandom;
            if (i % 4 == 1) b[31:16] = '1;
            if (i % 4 == 2) a[31:20] = '0;
            if (i % 4 == 3) begin a[31] = 1'b1; b = b | 32'hFFF0_0000; end
            run_mul(a, b, 1'b0);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        mcand_i = 32'h1357_9BDF; mplier_i = 32'h2468_ACE0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run reset busy", 64'(busy_o), 64'd0);
        check("R1 mid-run reset product", {hi_o, lo_o}, 64'd0);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (done_o || busy_o) seen++;
            end
            check("R1 no done after reset", 64'(seen), 64'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule